// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a free-running three-bit state machine that steps through a fixed, non-binary loop of five codes, one step per clock. The bits are written C B A, with C as the most significant bit. The loop is 000, 010, 011, 101, 110, and then back to 000. The state register is also the output, so the code seen at the port is the current state itself and needs no decoding.

Three of the eight codes are not in the loop: 001, 100 and 111. Each one has a fixed successor instead of being left as a don't-care. As a result, whatever value the register takes at power-up, it joins the loop within at most two clocks.

An active-high synchronous reset forces code 000. The parameter `INIT_CODE` sets the power-up value of the register, which lets an FPGA flow start the counter in any code.

Top module: `iseq_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `count_o` becomes 000 after that edge and stays at 000 for as long as `rst` stays high.
- R2: With `rst` low, `count_o` (bit 2 = C, bit 1 = B, bit 0 = A) steps 000 → 010 → 011 → 101 → 110 → 000, one step per rising edge.
- R3: The loop has a period of exactly five clocks: a loop code returns to `count_o` five edges after it was last seen, and not earlier.
- R4: Unused code 001 is followed by 110.
- R5: Unused code 100 is followed by 010.
- R6: Unused code 111 is followed by 100, and then by 010.
- R7: From any of the eight codes, `count_o` shows a loop code no later than the second rising edge.
- R8: The next state is given by C+ = A, B+ = (not B) or ((not A) and (not C)), and A+ = B and (not C). All eight codes follow these equations.
- R9: `count_o` changes only at rising edges of `clk` and is stable between them.
- R10: Before the first rising edge, `count_o` holds the value of the parameter `INIT_CODE` (default 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high; forces code 000 |
| count_o | output | 3 | Current state, bits {C,B,A} |

## Verification
A wrong successor for a loop code shows up at `count_o` on the very next edge. It then either cuts the loop short or stretches it past five codes, and a loop check catches that within one period. A wrong successor for an unused code cannot be reached from reset. To expose it, the bench builds extra counters whose power-up value is set to each unused code; any failure to recover then shows within two clocks of time zero. The next-state logic is also driven on its own with all eight codes, so an error in a single term of one equation is caught without waiting for the counter to wander into it.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int CODE_W = 3;
  localparam int LOOP_LEN = 5;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_S0 = 3'b000;
  localparam code_t CODE_S1 = 3'b010;
  localparam code_t CODE_S2 = 3'b011;
  localparam code_t CODE_S3 = 3'b101;
  localparam code_t CODE_S4 = 3'b110;
  localparam code_t CODE_X1 = 3'b001;
  localparam code_t CODE_X4 = 3'b100;
  localparam code_t CODE_X7 = 3'b111;

  // True when the code belongs to the five-code loop.
  function automatic logic on_loop(input code_t c);
    return (c == CODE_S0) || (c == CODE_S1) || (c == CODE_S2) ||
           (c == CODE_S3) || (c == CODE_S4);
  endfunction
endpackage

// File: rtl/iseq_next.sv
module iseq_next
  import iseq_pkg::*;
(
  input  logic [CODE_W-1:0] cur_i,
  output logic [CODE_W-1:0] nxt_o
);
  logic bit_c, bit_b, bit_a;

  always_comb begin
    bit_c = cur_i[2];
    bit_b = cur_i[1];
    bit_a = cur_i[0];
    // Sum-of-products chosen so that the three unused codes have defined exits.
    nxt_o[2] = bit_a;
    nxt_o[1] = ~bit_b | (~bit_a & ~bit_c);
    nxt_o[0] = bit_b & ~bit_c;
  end
endmodule

// File: rtl/iseq_reg.sv
module iseq_reg
  import iseq_pkg::*;
#(
  parameter logic [CODE_W-1:0] INIT_CODE = '0,
  parameter logic [CODE_W-1:0] RST_CODE  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] d_i,
  output logic [CODE_W-1:0] q_o
);
  logic [CODE_W-1:0] state_q = INIT_CODE;

  always_ff @(posedge clk) begin
    if (rst) state_q <= RST_CODE;
    else     state_q <= d_i;
  end

  assign q_o = state_q;

  assert_reset_value_R1: assert property (@(posedge clk) rst |=> (q_o == RST_CODE))
    else $error("reset did not load the reset code");
  assert_follow_d_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_o == $past(d_i)))
    else $error("register did not capture the next state");
endmodule

// File: rtl/iseq_counter.sv
module iseq_counter
  import iseq_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] count_o
);
  code_t cur_w;
  code_t nxt_w;

  iseq_next next_i (
    .cur_i (cur_w),
    .nxt_o (nxt_w)
  );

  iseq_reg #(
    .INIT_CODE (INIT_CODE),
    .RST_CODE  (CODE_S0)
  ) reg_i (
    .clk (clk),
    .rst (rst),
    .d_i (nxt_w),
    .q_o (cur_w)
  );

  assign count_o = cur_w;

  assert_loop_s0_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_S0) |=> (count_o == CODE_S1)) else $error("000 successor");
  assert_loop_s1_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_S1) |=> (count_o == CODE_S2)) else $error("010 successor");
  assert_loop_s2_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_S2) |=> (count_o == CODE_S3)) else $error("011 successor");
  assert_loop_s3_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_S3) |=> (count_o == CODE_S4)) else $error("101 successor");
  assert_loop_s4_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_S4) |=> (count_o == CODE_S0)) else $error("110 successor");
  assert_exit_001_R4: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_X1) |=> (count_o == CODE_S4)) else $error("001 exit");
  assert_exit_100_R5: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_X4) |=> (count_o == CODE_S1)) else $error("100 exit");
  assert_exit_111_R6: assert property (@(posedge clk) disable iff (rst)
    (count_o == CODE_X7) |=> (count_o == CODE_X4)) else $error("111 exit");
  assert_stay_on_loop_R7: assert property (@(posedge clk) disable iff (rst)
    on_loop(count_o) |=> on_loop(count_o)) else $error("left the loop");
endmodule

// File: tb/iseq_counter_tb_top.sv
module iseq_counter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] count_w;
  logic [2:0] rec1_w, rec4_w, rec7_w;
  logic [2:0] eq_cur = 3'b000;
  logic [2:0] eq_nxt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iseq_counter dut_i (.clk(clk), .rst(rst), .count_o(count_w));
  iseq_counter #(.INIT_CODE(3'b001)) rec1_i (.clk(clk), .rst(1'b0), .count_o(rec1_w));
  iseq_counter #(.INIT_CODE(3'b100)) rec4_i (.clk(clk), .rst(1'b0), .count_o(rec4_w));
  iseq_counter #(.INIT_CODE(3'b111)) rec7_i (.clk(clk), .rst(1'b0), .count_o(rec7_w));
  iseq_next eq_i (.cur_i(eq_cur), .nxt_o(eq_nxt));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] succ(input logic [2:0] c);
    case (c)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic bit is_loop(input logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b011 || c == 3'b101 || c == 3'b110;
  endfunction

  // Starts at time zero, before the first edge.
  task automatic t_recovery();
    #2;
    check("R10 init 001", rec1_w, 3'b001);
    check("R10 init 100", rec4_w, 3'b100);
    check("R10 init 111", rec7_w, 3'b111);
    @(negedge clk);
    check("R4 001->110", rec1_w, 3'b110);
    check("R5 100->010", rec4_w, 3'b010);
    check("R6 111->100", rec7_w, 3'b100);
    @(negedge clk);
    check("R4 then 000", rec1_w, 3'b000);
    check("R5 then 011", rec4_w, 3'b011);
    check("R6 100->010", rec7_w, 3'b010);
    check("R7 all on loop by two clocks", {2'b00, is_loop(rec1_w) & is_loop(rec4_w) & is_loop(rec7_w)}, 3'b001);
  endtask

  task automatic t_reset_hold();
    check("R1 held in reset", count_w, 3'b000);
    @(negedge clk);
    check("R1 still in reset", count_w, 3'b000);
  endtask

  task automatic t_main_loop();
    logic [2:0] exp_seq [5] = '{3'b010, 3'b011, 3'b101, 3'b110, 3'b000};
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 loop step", count_w, exp_seq[i]);
      #4;
      check("R9 stable between edges", count_w, exp_seq[i]);
    end
    @(negedge clk);
    check("R3 period five, back to 010", count_w, 3'b010);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    check("R2 before reset", count_w, 3'b011);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", count_w, 3'b000);
    @(negedge clk);
    check("R1 reset held", count_w, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check("R2 restart after reset", count_w, 3'b010);
  endtask

  task automatic t_equations();
    for (int c = 0; c < 8; c++) begin
      eq_cur = 3'(c);
      #1;
      check("R8 next-state equations", eq_nxt, succ(3'(c)));
    end
  endtask

  initial begin
    t_recovery();
    t_reset_hold();
    t_main_loop();
    t_mid_reset();
    t_equations();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule